// File: doc/BRIEF.md
# Switching-Cycle Protection Counter Bank

This block holds the cycle-based counters that a resonant half-bridge gate sequencer uses while it runs. The sequencer sends a one-clock pulse each time a switching period wraps, and a one-clock strobe when it drops into its idle state. The counter bank turns these into expiry flags.

- A startup flag tells the sequencer whether the startup dead-time clamp may still be used to leave a dead-time state.
- A burst flag and a burst-stop request let the sequencer halt switching while the feedback stays under the burst threshold.
- Two fault flags report when the over-current and bias-winding over-voltage budgets are used up.
- A saturating count gives the number of periods completed since the last idle entry.

All counters count down and stop at zero. They never wrap. Any idle entry reloads every counter except the startup counter. The startup counter is reloaded only when the enable has risen since the previous idle entry. Over-current pulses are collected across a switching period, so several pulses in one period cost only one count.

The burst-stop decision is a two-state machine, `GATE_RUN` and `GATE_HALT`. It has two transitions:
- `RUN_TO_HALT` is taken when the burst counter is at zero and feedback is below the threshold.
- `HALT_TO_RUN` is taken when the feedback flag clears.

Top module: `swcyc_counter_bank`

## Requirements
- R1: After reset, `startup_active`, `burst_expired`, `ocp_expired`, `ovp_expired` and `burst_stop` are 0, and `cycle_count` is 0. The burst counter resets to 15, the over-current counter to 4, and the over-voltage counter to `OVP_LOAD` (default 3).
- R2: An `idle_entry` strobe reloads the burst counter (15), the over-current counter (4) and the over-voltage counter (`OVP_LOAD`). It also clears `cycle_count` and discards any collected over-current pulse. In the same cycle it takes priority over `cycle_tick`, `ocp_evt` and `ovp_evt`, so in the next cycle the three expiry flags are 0 and `cycle_count` is 0.
- R3: The startup counter is loaded with 15 on an `idle_entry` only if `gen_en` has gone from 0 to 1 since the previous `idle_entry`. A rise in the same cycle as the strobe counts. Any other `idle_entry` leaves the startup counter unchanged.
- R4: The startup counter decreases by one on each `cycle_tick` and stops at 0. `startup_active` is 1 exactly while the counter is nonzero.
- R5: The burst counter decreases by one on each `cycle_tick` and stops at 0. `burst_expired` is 1 exactly while the counter is 0.
- R6: `burst_stop` goes to 1 in the cycle after a cycle in which `burst_expired` and `fb_below_burst` are both 1. It stays at 1 as long as `fb_below_burst` is 1. It returns to 0 in the cycle after `fb_below_burst` is 0.
- R7: The over-current counter decreases by one on a `cycle_tick` if at least one `ocp_evt` pulse was seen since the previous tick. A pulse in the tick cycle itself counts. Several pulses in one period cause a single decrease. The counter stops at 0, and `ocp_expired` is 1 while it is 0.
- R8: The over-voltage counter decreases by one for each cycle in which `ovp_evt` is 1, and stops at 0. `ovp_expired` is 1 while it is 0.
- R9: `cycle_count` increases by one on each `cycle_tick` and stops at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cycle_tick | input | 1 | One-clock pulse per completed switching period |
| idle_entry | input | 1 | One-clock strobe when the sequencer enters idle |
| gen_en | input | 1 | Waveform generator enable level |
| ocp_evt | input | 1 | Over-current event pulse |
| ovp_evt | input | 1 | Bias-winding over-voltage event pulse |
| fb_below_burst | input | 1 | Feedback is below the burst threshold |
| startup_active | output | 1 | Startup dead-time clamp exit still permitted |
| burst_expired | output | 1 | Burst cycle counter at zero |
| ocp_expired | output | 1 | Over-current counter at zero |
| ovp_expired | output | 1 | Over-voltage counter at zero |
| burst_stop | output | 1 | Request to halt switching for burst mode |
| cycle_count | output | CYC_W | Saturating count of switching periods since idle |

## Verification
The assertions check on every cycle the properties that depend on only one or two cycles:
- the preconditions for `burst_stop` to rise and to hold;
- the effect of an idle strobe on the flags and the count;
- the single-step increment of the cycle count;
- that each expired flag stays set until the next idle strobe.

Only the bench's scenarios can show the properties that depend on longer histories:
- the exact number of periods before each counter reaches zero;
- the merging of several over-current pulses within one period;
- the remembered enable rise that decides whether the startup counter reloads;
- saturation of the cycle count after a long run.

// File: rtl/swcyc_pkg.sv
package swcyc_pkg;
    typedef enum logic [0:0] {
        GATE_RUN  = 1'b0,
        GATE_HALT = 1'b1
    } burst_gate_t;

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/swcyc_sat_down.sv
module swcyc_sat_down #(
    parameter int W       = 4,
    parameter int LOAD    = 15,
    parameter int RST_VAL = 15
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= W'(RST_VAL);
        end else if (load) begin
            cnt <= W'(LOAD);
        end else if (dec && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/swcyc_evt_latch.sv
module swcyc_evt_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic any
);
    logic seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= 1'b0;
        end else if (clr) begin
            seen <= 1'b0;
        end else if (evt) begin
            seen <= 1'b1;
        end
    end

    assign any = seen | evt;
endmodule

// File: rtl/swcyc_burst_gate.sv
module swcyc_burst_gate
    import swcyc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic burst_zero,
    input  logic fb_below,
    output logic stop
);
    burst_gate_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            GATE_RUN:  if (burst_zero && fb_below) state_nx = GATE_HALT; // RUN_TO_HALT
            GATE_HALT: if (!fb_below)              state_nx = GATE_RUN;  // HALT_TO_RUN
            default:                               state_nx = GATE_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GATE_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        unique case (state)
            GATE_HALT: stop = 1'b1;
            default:   stop = 1'b0;
        endcase
    end
endmodule

// File: rtl/swcyc_counter_bank.sv
module swcyc_counter_bank
    import swcyc_pkg::*;
#(
    parameter int STARTUP_LOAD = 15,
    parameter int BURST_LOAD   = 15,
    parameter int OCP_LOAD     = 4,
    parameter int OVP_LOAD     = 3,
    parameter int CYC_W        = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cycle_tick,
    input  logic             idle_entry,
    input  logic             gen_en,
    input  logic             ocp_evt,
    input  logic             ovp_evt,
    input  logic             fb_below_burst,
    output logic             startup_active,
    output logic             burst_expired,
    output logic             ocp_expired,
    output logic             ovp_expired,
    output logic             burst_stop,
    output logic [CYC_W-1:0] cycle_count
);
    localparam int MAX_LOAD = max4(STARTUP_LOAD, BURST_LOAD, OCP_LOAD, OVP_LOAD);
    localparam int CNT_W    = (MAX_LOAD < 2) ? 1 : $clog2(MAX_LOAD + 1);

    logic en_q, rise_pend, en_rise, st_load, st_zero, ocp_any;

    assign en_rise = gen_en & ~en_q;
    assign st_load = idle_entry & (rise_pend | en_rise);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q      <= 1'b0;
            rise_pend <= 1'b0;
        end else begin
            en_q      <= gen_en;
            rise_pend <= idle_entry ? 1'b0 : (rise_pend | en_rise);
        end
    end

    swcyc_sat_down #(.W(CNT_W), .LOAD(STARTUP_LOAD), .RST_VAL(0)) u_startup (
        .clk(clk), .rst_n(rst_n), .load(st_load), .dec(cycle_tick), .zero(st_zero));

    swcyc_sat_down #(.W(CNT_W), .LOAD(BURST_LOAD), .RST_VAL(BURST_LOAD)) u_burst (
        .clk(clk), .rst_n(rst_n), .load(idle_entry), .dec(cycle_tick), .zero(burst_expired));

    swcyc_evt_latch u_ocp_latch (
        .clk(clk), .rst_n(rst_n), .evt(ocp_evt), .clr(cycle_tick | idle_entry), .any(ocp_any));

    swcyc_sat_down #(.W(CNT_W), .LOAD(OCP_LOAD), .RST_VAL(OCP_LOAD)) u_ocp (
        .clk(clk), .rst_n(rst_n), .load(idle_entry), .dec(cycle_tick & ocp_any), .zero(ocp_expired));

    swcyc_sat_down #(.W(CNT_W), .LOAD(OVP_LOAD), .RST_VAL(OVP_LOAD)) u_ovp (
        .clk(clk), .rst_n(rst_n), .load(idle_entry), .dec(ovp_evt), .zero(ovp_expired));

    assign startup_active = ~st_zero;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cycle_count <= '0;
        end else if (idle_entry) begin
            cycle_count <= '0;
        end else if (cycle_tick && (cycle_count != '1)) begin
            cycle_count <= cycle_count + 1'b1;
        end
    end

    swcyc_burst_gate u_gate (
        .clk(clk), .rst_n(rst_n), .burst_zero(burst_expired),
        .fb_below(fb_below_burst), .stop(burst_stop));
endmodule

// File: rtl/swcyc_counter_bank_chk.sv
module swcyc_counter_bank_chk #(
    parameter int CYC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cycle_tick,
    input logic             idle_entry,
    input logic             fb_below_burst,
    input logic             startup_active,
    input logic             burst_expired,
    input logic             ocp_expired,
    input logic             ovp_expired,
    input logic             burst_stop,
    input logic [CYC_W-1:0] cycle_count
);
    // R6
    stop_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_stop) |-> $past(burst_expired && fb_below_burst));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && fb_below_burst) |=> burst_stop);

    // R6
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_stop && !fb_below_burst) |=> !burst_stop);

    // R2
    idle_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_entry |=> (!burst_expired && !ocp_expired && !ovp_expired && (cycle_count == '0)));

    // R9
    cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_tick && !idle_entry && (cycle_count != '1)) |=> (cycle_count == $past(cycle_count) + 1'b1));

    // R4
    startup_stays_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!startup_active && !idle_entry) |=> !startup_active);

    // R7
    ocp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ocp_expired && !idle_entry) |=> ocp_expired);

    // R8
    ovp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovp_expired && !idle_entry) |=> ovp_expired);

    // R5
    burst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_expired && !idle_entry) |=> burst_expired);
endmodule

bind swcyc_counter_bank swcyc_counter_bank_chk #(.CYC_W(CYC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick), .idle_entry(idle_entry),
    .fb_below_burst(fb_below_burst), .startup_active(startup_active),
    .burst_expired(burst_expired), .ocp_expired(ocp_expired), .ovp_expired(ovp_expired),
    .burst_stop(burst_stop), .cycle_count(cycle_count));

// File: tb/tb_swcyc_counter_bank.sv
module tb_swcyc_counter_bank;
    localparam int OVP_L = 3;
    localparam int CW    = 8;
    localparam int CMAX  = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cycle_tick = 0, idle_entry = 0, gen_en = 0, ocp_evt = 0, ovp_evt = 0, fb_below_burst = 0;
    logic startup_active, burst_expired, ocp_expired, ovp_expired, burst_stop;
    logic [CW-1:0] cycle_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_st, m_bu, m_oc, m_ov, m_cy;
    bit m_pend, m_enq, m_ocs, m_halt;

    always #10 clk = ~clk;

    swcyc_counter_bank #(.OVP_LOAD(OVP_L), .CYC_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .cycle_tick(cycle_tick), .idle_entry(idle_entry),
        .gen_en(gen_en), .ocp_evt(ocp_evt), .ovp_evt(ovp_evt), .fb_below_burst(fb_below_burst),
        .startup_active(startup_active), .burst_expired(burst_expired), .ocp_expired(ocp_expired),
        .ovp_expired(ovp_expired), .burst_stop(burst_stop), .cycle_count(cycle_count));

    function automatic int dec_sat(input int v, input bit d);
        return (d && v > 0) ? v - 1 : v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_bu = 15; m_oc = 4; m_ov = OVP_L; m_cy = 0;
        m_pend = 0; m_enq = 0; m_ocs = 0; m_halt = 0;
    endtask

    task automatic model_step(input bit t, input bit i, input bit e, input bit o, input bit v, input bit f);
        bit rise, ocp_any;
        rise = e & ~m_enq;
        ocp_any = m_ocs | o;
        m_halt = m_halt ? f : ((m_bu == 0) && f);
        if (i && (m_pend || rise)) m_st = 15;
        else m_st = dec_sat(m_st, t);
        if (i) begin
            m_bu = 15; m_oc = 4; m_ov = OVP_L; m_cy = 0;
        end else begin
            m_bu = dec_sat(m_bu, t);
            m_oc = dec_sat(m_oc, t && ocp_any);
            m_ov = dec_sat(m_ov, v);
            if (t && m_cy < CMAX) m_cy = m_cy + 1;
        end
        m_ocs = (t || i) ? 1'b0 : ocp_any;
        m_pend = i ? 1'b0 : (m_pend | rise);
        m_enq = e;
    endtask

    task automatic compare_all();
        check("R4 startup_active", startup_active, m_st != 0);
        check("R5 burst_expired", burst_expired, m_bu == 0);
        check("R7 ocp_expired", ocp_expired, m_oc == 0);
        check("R8 ovp_expired", ovp_expired, m_ov == 0);
        check("R6 burst_stop", burst_stop, m_halt);
        check("R9 cycle_count", cycle_count, m_cy);
    endtask

    task automatic cyc(input bit t, input bit i, input bit e, input bit o, input bit v, input bit f);
        cycle_tick = t; idle_entry = i; gen_en = e; ocp_evt = o; ovp_evt = v; fb_below_burst = f;
        model_step(t, i, e, o, v, f);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 startup_active", startup_active, 0);
        check("R1 burst_expired", burst_expired, 0);
        check("R1 ocp_expired", ocp_expired, 0);
        check("R1 ovp_expired", ovp_expired, 0);
        check("R1 burst_stop", burst_stop, 0);
        check("R1 cycle_count", cycle_count, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: enable rises, later idle entry loads startup
        cyc(0, 0, 1, 0, 0, 0);
        cyc(0, 1, 1, 0, 0, 0);
        check("R3 reload after rise", startup_active, 1);
        // R4/R5: 14 ticks keep both alive, the 15th expires them
        for (int k = 0; k < 14; k++) cyc(1, 0, 1, 0, 0, 0);
        check("R4 startup still active", startup_active, 1);
        check("R5 burst not yet expired", burst_expired, 0);
        cyc(1, 0, 1, 0, 0, 0);
        check("R4 startup spent", startup_active, 0);
        check("R5 burst expired", burst_expired, 1);
        // R6: feedback low triggers stop one cycle later, clears after feedback
        cyc(0, 0, 1, 0, 0, 1);
        check("R6 stop asserted", burst_stop, 1);
        cyc(0, 0, 1, 0, 0, 1);
        check("R6 stop held", burst_stop, 1);
        cyc(0, 0, 1, 0, 0, 0);
        check("R6 stop released", burst_stop, 0);
        // R3: idle without a new rise leaves startup at zero
        cyc(1, 1, 1, 0, 1, 0);
        check("R3 no reload without rise", startup_active, 0);
        // R2: idle with tick and events in same cycle still reloads
        check("R2 burst reloaded", burst_expired, 0);
        check("R2 ovp reloaded", ovp_expired, 0);
        check("R2 count cleared", cycle_count, 0);
        // R7: three pulses in one period cost one count
        for (int p = 0; p < 3; p++) begin
            cyc(0, 0, 1, 1, 0, 0); cyc(0, 0, 1, 1, 0, 0); cyc(1, 0, 1, 1, 0, 0);
        end
        check("R7 ocp not yet expired", ocp_expired, 0);
        cyc(0, 0, 1, 1, 0, 0);
        cyc(1, 0, 1, 0, 0, 0);
        check("R7 ocp expired", ocp_expired, 1);
        // R8: each pulse counts
        cyc(0, 0, 1, 0, 1, 0); cyc(0, 0, 1, 0, 1, 0);
        check("R8 ovp not yet expired", ovp_expired, 0);
        cyc(0, 0, 1, 0, 1, 0);
        check("R8 ovp expired", ovp_expired, 1);
        // R9: saturation
        for (int k = 0; k < CMAX + 5; k++) cyc(1, 0, 1, 0, 0, 0);
        check("R9 count saturated", cycle_count, CMAX);
        // R3: rise in same cycle as idle
        cyc(0, 0, 0, 0, 0, 0);
        cyc(0, 1, 1, 0, 0, 0);
        check("R3 same-cycle rise reload", startup_active, 1);

        // constrained random phase
        for (int n = 0; n < 5000; n++) begin
            bit t, i, o, v;
            t = ($urandom % 3) == 0;
            i = ($urandom % 60) == 0;
            o = ($urandom % 5) == 0;
            v = ($urandom % 40) == 0;
            if (($urandom % 25) == 0) gen_en = ~gen_en;
            if (($urandom % 12) == 0) fb_below_burst = ~fb_below_burst;
            cyc(t, i, gen_en, o, v, fb_below_burst);
        end
        done = 1;
    end

    initial begin
        for (int w = 0; w < 100000; w++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual 0 expected 1 (run completion)");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule